// File: doc/BRIEF.md
# Bus Bridge DMA Controller

A memory-mapped slave peripheral that moves 32-bit words between a host register interface and an abstract external bus. The host fills an outbound FIFO word by word and drains an inbound FIFO word by word. A block transfer between one of these FIFOs and the external bus is started by writing a byte count. The transfer uses a request/acknowledge word handshake that carries a target address and a direction.

Five modes set the direction of a transfer and whether its end raises an interrupt. A loopback mode drains the inbound FIFO onto the external bus on its own whenever that FIFO holds data. The host reads the interrupt state, together with a busy flag, from a status register. Any write to that register clears the interrupt.

Top module: `xbus_dma_bridge`

## Requirements
- R1: Registers are selected by address bits [4:2] only: VALUE 0x00, MODE 0x04, ADR 0x08, STATUS 0x0C, NB 0x10. Offsets 0x14–0x1C read 0 and ignore writes. After reset MODE, ADR, NB, the interrupt and the busy flag are all 0.
- R2: A write to VALUE appends the word to the outbound FIFO (1024 words). When that FIFO already holds 1024 words, the write is dropped.
- R3: A read of VALUE returns the oldest inbound word and removes it. When the inbound FIFO is empty, the read returns 0 and changes nothing.
- R4: MODE codes: 0 = bus to inbound with interrupt, 1 = bus to inbound quiet, 2 = outbound to bus with interrupt, 3 = outbound to bus quiet, 4 = loopback. A write of 5, 6 or 7 leaves MODE unchanged.
- R5: A write to NB, made while the block is idle in modes 0–3 with a length from 1 to 4096 that passes the readiness check, sets busy and starts a transfer of ceil(NB/4) words. `xb_req_o` is held high until the last acknowledged word, and `xb_addr_o` equals ADR.
- R6: In modes 2 and 3, each word is presented with `xb_write_o`=1 and `xb_wdata_o` equal to the oldest outbound word. The word is removed on `xb_ack_i`.
- R7: In modes 0 and 1, each word is presented with `xb_write_o`=0. `xb_rdata_i` is appended to the inbound FIFO on `xb_ack_i`.
- R8: Readiness check: an outbound transfer needs the outbound FIFO to hold at least ceil(NB/4) words. An inbound transfer needs the inbound FIFO to have at least that many free slots. NB=0, NB>4096, loopback mode or a failed check stores the NB value without starting a transfer.
- R9: The interrupt output rises one cycle after the final acknowledge in modes 0 and 2, and never in modes 1, 3 or 4. It stays high until a write to STATUS. A completion and a clear in the same cycle leave it set.
- R10: A STATUS read returns the interrupt in bit 0 and busy in bit 1, with the other bits 0.
- R11: While busy, writes to MODE, ADR and NB are ignored.
- R12: In loopback mode while idle, the oldest inbound word is offered with `xb_write_o`=1 and removed on acknowledge. In this mode, host reads of VALUE return 0 and remove nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req_i | input | 1 | Host access strobe, one access per cycle |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 12 | Byte offset inside the 4 KB window |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Host read data, valid in the access cycle |
| irq_o | output | 1 | Pending end-of-transfer interrupt |
| xb_req_o | output | 1 | External bus word request |
| xb_write_o | output | 1 | 1 = word goes out to the bus, 0 = word comes in |
| xb_addr_o | output | 32 | External bus target address |
| xb_wdata_o | output | 32 | Outgoing word |
| xb_ack_i | input | 1 | Word accepted or delivered this cycle |
| xb_rdata_i | input | 32 | Incoming word, valid with acknowledge |

## Verification
Outbound transfers are run with an acknowledge held high and with a pseudo-random acknowledge. This separates word ordering from handshake stalls. Byte counts of 16, 13 and 4096 check the rounding up to whole words and the full-depth boundary. Inbound transfers are followed by more reads than were delivered, to expose the zero returned from an empty FIFO. Starts are attempted with too few words, with a zero count, with an oversized count and in loopback, to tell a recorded NB from a launched one. Register writes are made during a stalled transfer to show the busy lock. Loopback is run after an inbound fill, to show automatic forwarding with no interrupt.

// File: rtl/bdma_pkg.sv
`timescale 1ns/1ps
package bdma_pkg;
  typedef enum logic [2:0] {
    MODE_IN_IRQ    = 3'd0,
    MODE_IN_QUIET  = 3'd1,
    MODE_OUT_IRQ   = 3'd2,
    MODE_OUT_QUIET = 3'd3,
    MODE_LOOP      = 3'd4
  } mode_e;

  typedef enum logic [2:0] {
    SEL_VALUE  = 3'd0,
    SEL_MODE   = 3'd1,
    SEL_ADR    = 3'd2,
    SEL_STATUS = 3'd3,
    SEL_NB     = 3'd4
  } sel_e;

  localparam int unsigned MODE_LAST = 4;
endpackage

// File: rtl/bdma_fifo.sv
`timescale 1ns/1ps
// Word FIFO; DEPTH must be a power of two. Push is refused when full,
// pop is refused when empty; both may happen in one cycle.
module bdma_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 1024,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              push_ok, pop_ok;

  assign push_ok = push_i && (cnt_q != CNT_W'(DEPTH));
  assign pop_ok  = pop_i && (cnt_q != '0);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_ok) wr_ptr_d = wr_ptr_q + 1'b1;
    if (pop_ok)  rd_ptr_d = rd_ptr_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= push_data_i;
  end

  assign head_o  = mem[rd_ptr_q];
  assign count_o = cnt_q;
  assign empty_o = (cnt_q == '0);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_W'(DEPTH));
  assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == CNT_W'(DEPTH) && !pop_i) |=> (count_o == CNT_W'(DEPTH)));
  assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_i && !push_i) |=> empty_o);
endmodule

// File: rtl/bdma_regs.sv
`timescale 1ns/1ps
module bdma_regs
  import bdma_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              irq_i,
  input  logic [DATA_W-1:0] in_head_i,
  input  logic              in_empty_i,
  output mode_e             mode_o,
  output logic [DATA_W-1:0] adr_o,
  output logic [DATA_W-1:0] nb_o,
  output logic              nb_wr_o,
  output logic              irq_clr_o,
  output logic              out_push_o,
  output logic              in_pop_o
);
  logic [2:0]        sel;
  logic              wr, rd;
  logic              addr_unused;
  mode_e             mode_q, mode_d;
  logic [DATA_W-1:0] adr_q, adr_d, nb_q, nb_d;
  logic              mode_en, adr_en, nb_en;

  assign sel         = addr_i[4:2];
  assign addr_unused = ^{addr_i[ADDR_W-1:5], addr_i[1:0]};
  assign wr          = req_i && we_i;
  assign rd          = req_i && !we_i;

  assign mode_en = wr && (sel == SEL_MODE) && !busy_i &&
                   (wdata_i <= DATA_W'(MODE_LAST));
  assign adr_en  = wr && (sel == SEL_ADR) && !busy_i;
  assign nb_en   = wr && (sel == SEL_NB) && !busy_i;

  always_comb begin
    mode_d = mode_q;
    adr_d  = adr_q;
    nb_d   = nb_q;
    if (mode_en) mode_d = mode_e'(wdata_i[2:0]);
    if (adr_en)  adr_d  = wdata_i;
    if (nb_en)   nb_d   = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IN_IRQ;
      adr_q  <= '0;
      nb_q   <= '0;
    end else begin
      mode_q <= mode_d;
      adr_q  <= adr_d;
      nb_q   <= nb_d;
    end
  end

  assign out_push_o = wr && (sel == SEL_VALUE);
  assign in_pop_o   = rd && (sel == SEL_VALUE) && (mode_q != MODE_LOOP);
  assign irq_clr_o  = wr && (sel == SEL_STATUS);
  assign nb_wr_o    = nb_en;
  assign nb_o       = wdata_i;
  assign mode_o     = mode_q;
  assign adr_o      = adr_q;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (sel)
        SEL_VALUE:  rdata_o = (mode_q != MODE_LOOP && !in_empty_i) ? in_head_i : '0;
        SEL_MODE:   rdata_o = DATA_W'(mode_q);
        SEL_ADR:    rdata_o = adr_q;
        SEL_STATUS: rdata_o = DATA_W'({busy_i, irq_i});
        SEL_NB:     rdata_o = nb_q;
        default:    rdata_o = '0;
      endcase
    end
  end

  assert_locked_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(mode_q));
  assert_locked_adr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(adr_q));
  assert_mode_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q <= MODE_LOOP);
endmodule

// File: rtl/bdma_engine.sv
`timescale 1ns/1ps
module bdma_engine
  import bdma_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 1024,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned LEN_W = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode_i,
  input  logic [DATA_W-1:0] adr_i,
  input  logic [DATA_W-1:0] nb_i,
  input  logic              nb_wr_i,
  input  logic              irq_clr_i,
  input  logic [CNT_W-1:0]  out_count_i,
  input  logic [DATA_W-1:0] out_head_i,
  input  logic [CNT_W-1:0]  in_count_i,
  input  logic [DATA_W-1:0] in_head_i,
  output logic              out_pop_o,
  output logic              in_push_o,
  output logic              lb_pop_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic              xb_req_o,
  output logic              xb_write_o,
  output logic [DATA_W-1:0] xb_addr_o,
  output logic [DATA_W-1:0] xb_wdata_o,
  input  logic              xb_ack_i
);
  localparam logic [DATA_W-1:0] MAX_BYTES = DATA_W'(DEPTH * 4);

  logic             busy_q, busy_d, dir_q, dir_d, irq_q, irq_d;
  logic [CNT_W-1:0] rem_q, rem_d, words, in_free;
  logic             len_ok, is_out, ready, start, beat, last, lb_active, irq_mode;

  assign len_ok   = (nb_i != '0) && (nb_i <= MAX_BYTES);
  assign words    = CNT_W'((LEN_W'(nb_i[LEN_W-1:0]) + LEN_W'(3)) >> 2);
  assign is_out   = (mode_i == MODE_OUT_IRQ) || (mode_i == MODE_OUT_QUIET);
  assign in_free  = CNT_W'(DEPTH) - in_count_i;
  assign ready    = is_out ? (out_count_i >= words) : (in_free >= words);
  assign start    = nb_wr_i && !busy_q && len_ok && (mode_i != MODE_LOOP) && ready;
  assign irq_mode = (mode_i == MODE_IN_IRQ) || (mode_i == MODE_OUT_IRQ);

  assign beat      = busy_q && xb_ack_i;
  assign last      = beat && (rem_q == CNT_W'(1));
  assign lb_active = !busy_q && (mode_i == MODE_LOOP) && (in_count_i != '0);

  always_comb begin
    busy_d = busy_q;
    dir_d  = dir_q;
    rem_d  = rem_q;
    irq_d  = irq_q;
    if (start) begin
      busy_d = 1'b1;
      dir_d  = is_out;
      rem_d  = words;
    end else if (beat) begin
      rem_d = rem_q - 1'b1;
      if (last) busy_d = 1'b0;
    end
    if (last && irq_mode)  irq_d = 1'b1;
    else if (irq_clr_i)    irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      rem_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      dir_q  <= dir_d;
      rem_q  <= rem_d;
      irq_q  <= irq_d;
    end
  end

  assign out_pop_o  = beat && dir_q;
  assign in_push_o  = beat && !dir_q;
  assign lb_pop_o   = lb_active && xb_ack_i;
  assign busy_o     = busy_q;
  assign irq_o      = irq_q;
  assign xb_req_o   = busy_q || lb_active;
  assign xb_write_o = busy_q ? dir_q : 1'b1;
  assign xb_addr_o  = adr_i;
  assign xb_wdata_o = (busy_q && dir_q) ? out_head_i : in_head_i;

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(busy_q));
  assert_busy_rem_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q != '0));
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !xb_ack_i) |=> (xb_req_o && $stable(xb_addr_o)));
  assert_out_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && dir_q && !xb_ack_i) |=> $stable(xb_wdata_o));
  assert_loop_dir_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (xb_req_o && !busy_q) |-> xb_write_o);
endmodule

// File: rtl/xbus_dma_bridge.sv
`timescale 1ns/1ps
module xbus_dma_bridge
  import bdma_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DEPTH  = 1024,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              xb_req_o,
  output logic              xb_write_o,
  output logic [DATA_W-1:0] xb_addr_o,
  output logic [DATA_W-1:0] xb_wdata_o,
  input  logic              xb_ack_i,
  input  logic [DATA_W-1:0] xb_rdata_i
);
  mode_e             mode;
  logic [DATA_W-1:0] adr, nb, out_head, in_head;
  logic [CNT_W-1:0]  out_count, in_count;
  logic              nb_wr, irq_clr, out_push, host_pop, out_pop, in_push, lb_pop;
  logic              busy, out_empty, in_empty, out_empty_unused;

  assign out_empty_unused = out_empty;

  bdma_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_i(reg_req_i), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy), .irq_i(irq_o),
    .in_head_i(in_head), .in_empty_i(in_empty),
    .mode_o(mode), .adr_o(adr), .nb_o(nb), .nb_wr_o(nb_wr),
    .irq_clr_o(irq_clr), .out_push_o(out_push), .in_pop_o(host_pop)
  );

  bdma_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_out_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_i(out_push), .push_data_i(reg_wdata_i), .pop_i(out_pop),
    .head_o(out_head), .count_o(out_count), .empty_o(out_empty)
  );

  bdma_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_in_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_i(in_push), .push_data_i(xb_rdata_i), .pop_i(host_pop || lb_pop),
    .head_o(in_head), .count_o(in_count), .empty_o(in_empty)
  );

  bdma_engine #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .mode_i(mode), .adr_i(adr), .nb_i(nb), .nb_wr_i(nb_wr), .irq_clr_i(irq_clr),
    .out_count_i(out_count), .out_head_i(out_head),
    .in_count_i(in_count), .in_head_i(in_head),
    .out_pop_o(out_pop), .in_push_o(in_push), .lb_pop_o(lb_pop),
    .busy_o(busy), .irq_o(irq_o),
    .xb_req_o(xb_req_o), .xb_write_o(xb_write_o), .xb_addr_o(xb_addr_o),
    .xb_wdata_o(xb_wdata_o), .xb_ack_i(xb_ack_i)
  );

  assert_single_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_pop && lb_pop));
endmodule

// File: tb/xbus_dma_bridge_tb.sv
`timescale 1ns/1ps
module xbus_dma_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, xb_req, xb_write, xb_ack = 1'b0;
  logic [31:0] xb_addr, xb_wdata, xb_rdata = '0;

  int unsigned n_checks = 0, n_fails = 0;
  bit          done = 1'b0, ack_en = 1'b0, ack_always = 1'b1;
  logic [31:0] lfsr = 32'h1234_abcd;

  always #2.5 clk = ~clk;

  xbus_dma_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .xb_req_o(xb_req), .xb_write_o(xb_write), .xb_addr_o(xb_addr),
    .xb_wdata_o(xb_wdata), .xb_ack_i(xb_ack), .xb_rdata_i(xb_rdata)
  );

  // behavioural reference model
  logic [31:0] m_outq[$], m_inq[$];
  logic [31:0] m_adr, m_nb;
  int          m_mode, m_rem;
  bit          m_busy, m_dir, m_irq;

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // external bus responder
  always @(posedge clk) begin
    lfsr    <= {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    xb_ack  <= ack_en && (ack_always || lfsr[3]);
    xb_rdata <= lfsr ^ 32'h5a5a_0000;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_outq.delete(); m_inq.delete();
      m_adr = '0; m_nb = '0; m_mode = 0; m_rem = 0;
      m_busy = 0; m_dir = 0; m_irq = 0;
    end else begin
      bit h_wr, h_rd, beat, last, lb, pre_busy, irqm, outm;
      int off, osz, isz, w;
      h_wr = reg_req && reg_we;
      h_rd = reg_req && !reg_we;
      off  = int'(reg_addr[4:2]);
      osz  = m_outq.size();
      isz  = m_inq.size();
      pre_busy = m_busy;
      beat = m_busy && xb_ack;
      last = beat && m_rem == 1;
      lb   = !m_busy && m_mode == 4 && isz > 0 && xb_ack;
      irqm = (m_mode == 0 || m_mode == 2);
      if (beat && m_dir) void'(m_outq.pop_front());
      if (lb) void'(m_inq.pop_front());
      if (h_rd && off == 0 && m_mode != 4 && isz > 0) void'(m_inq.pop_front());
      if (beat && !m_dir) m_inq.push_back(xb_rdata);
      if (h_wr && off == 0 && osz < 1024) m_outq.push_back(reg_wdata);
      if (last && irqm) m_irq = 1;
      else if (h_wr && off == 3) m_irq = 0;
      if (beat) begin
        m_rem--;
        if (m_rem == 0) m_busy = 0;
      end else if (h_wr && off == 4 && !pre_busy) begin
        m_nb = reg_wdata;
        outm = (m_mode == 2 || m_mode == 3);
        w = int'((reg_wdata + 3) / 4);
        if (reg_wdata != 0 && reg_wdata <= 4096 && m_mode != 4 &&
            (outm ? osz >= w : (1024 - isz) >= w)) begin
          m_busy = 1; m_dir = outm; m_rem = w;
        end
      end
      if (h_wr && off == 1 && !pre_busy && reg_wdata <= 4) m_mode = int'(reg_wdata);
      if (h_wr && off == 2 && !pre_busy) m_adr = reg_wdata;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit er, ew;
      er = m_busy || (m_mode == 4 && m_inq.size() > 0);
      ew = m_busy ? m_dir : 1'b1;
      chk({31'b0, xb_req}, {31'b0, er}, "R5 xb_req");
      chk({31'b0, irq}, {31'b0, m_irq}, "R9 irq");
      if (er) begin
        chk({31'b0, xb_write}, {31'b0, ew}, "R6/R7 xb_write");
        chk(xb_addr, m_adr, "R5 xb_addr");
        if (ew) chk(xb_wdata, m_busy ? m_outq[0] : m_inq[0],
                    m_busy ? "R6/R2 xb_wdata" : "R12 xb_wdata");
      end
      if (reg_req && !reg_we) begin
        case (reg_addr[4:2])
          3'd0: chk(reg_rdata, (m_mode != 4 && m_inq.size() > 0) ? m_inq[0] : 32'h0,
                    "R3/R7/R12 VALUE read");
          3'd1: chk(reg_rdata, 32'(m_mode), "R4/R11 MODE read");
          3'd2: chk(reg_rdata, m_adr, "R11 ADR read");
          3'd3: chk(reg_rdata, {30'b0, m_busy, m_irq}, "R10 STATUS read");
          3'd4: chk(reg_rdata, m_nb, "R8/R11 NB read");
          default: chk(reg_rdata, 32'h0, "R1 unmapped read");
        endcase
      end
    end
  end

  task automatic acc(bit we, int off, logic [31:0] d, logic [11:0] hi = '0);
    reg_req = 1'b1; reg_we = we; reg_addr = hi | 12'(off * 4); reg_wdata = d;
    @(posedge clk); #1;
    reg_req = 1'b0; reg_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 6000; n++) begin
      if (!(m_busy || (m_mode == 4 && m_inq.size() > 0))) break;
      @(posedge clk); #1;
    end
  endtask

  task automatic summary();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: reset values, unmapped offsets, aliasing through upper address bits
    for (int i = 0; i < 8; i++) acc(0, i, 0);
    acc(1, 6, 32'hffff_ffff);
    acc(0, 2, 0, 12'h400);
    // R4: illegal mode codes ignored
    acc(1, 1, 3); acc(1, 1, 7); acc(0, 1, 0);
    acc(1, 2, 32'h0000_0017);
    // R5/R6: outbound, quiet, ack always
    ack_en = 1;
    for (int i = 0; i < 4; i++) acc(1, 0, 32'h100 + i);
    acc(1, 4, 16); wait_idle(); acc(0, 3, 0);
    // R9/R5: outbound with interrupt, 13 bytes rounds to 4 words, random ack
    ack_always = 0;
    acc(1, 1, 2);
    for (int i = 0; i < 5; i++) acc(1, 0, 32'h200 + i);
    acc(1, 4, 13); wait_idle(); acc(0, 3, 0); acc(1, 3, 0); acc(0, 3, 0);
    // R8: too few words, zero, oversized, loopback
    acc(1, 4, 40); acc(0, 4, 0); acc(0, 3, 0);
    acc(1, 4, 0); acc(1, 4, 5000); acc(0, 3, 0);
    acc(1, 4, 4); wait_idle();
    // R7/R3: inbound with interrupt, then over-read
    acc(1, 1, 0); acc(1, 4, 8); wait_idle();
    for (int i = 0; i < 3; i++) acc(0, 0, 0);
    acc(1, 3, 0);
    // R7/R9: inbound quiet, no interrupt
    acc(1, 1, 1); acc(1, 4, 12); wait_idle(); acc(0, 3, 0);
    acc(0, 0, 0);
    // R11: lock while busy, acknowledge stalled
    ack_en = 0;
    acc(1, 1, 3); acc(1, 0, 32'hbeef);
    acc(1, 4, 4); acc(1, 1, 0); acc(1, 2, 32'h99); acc(1, 4, 64);
    acc(0, 1, 0); acc(0, 2, 0); acc(0, 4, 0); acc(0, 3, 0);
    ack_en = 1; wait_idle();
    // R12: loopback forwards remaining inbound words, no interrupt
    ack_en = 0;
    acc(1, 1, 4); acc(0, 0, 0); acc(1, 4, 8); acc(0, 3, 0);
    ack_en = 1; wait_idle(); acc(0, 3, 0);
    acc(1, 1, 3);
    // R2: fill to 1024, one dropped write, full-depth transfer
    ack_always = 1;
    for (int i = 0; i < 1025; i++) acc(1, 0, 32'h4000_0000 + i);
    acc(1, 4, 4096); wait_idle();
    acc(1, 0, 32'hcafe); acc(1, 4, 4); wait_idle();
    acc(0, 3, 0);
    repeat (4) @(posedge clk);
    summary();
  end
endmodule